// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Channel

This block is one copy channel of a DMA controller with 40-bit addressing. Work is described by control blocks that sit in memory. Software writes a block pointer into the channel, stored as the byte address shifted right by five, and then sets the run bit. The channel reads the block and copies the data one word at a time, from the source address to the destination address. It then follows the block's next pointer. When it reaches a null pointer it sets an end flag, and it can raise an interrupt after any block.

Software reaches the channel through a small register port. Writes take effect on a clock edge and reads are combinational. The channel reaches memory through a word-wide read request path with a separate response strobe, and a word-wide write request path. Both request paths use valid/ready handshakes. Priority fields, the debug word and the beat-size and burst fields are only stored and returned on reads. The copy itself always moves 32-bit words.

The control FSM has six states:
- IDLE goes to FETCH on start when the pointer is non-zero.
- FETCH reads seven words. It then goes to COPY_RD, to NEXT for a zero length, or back to IDLE when the length is too large.
- COPY_RD goes to COPY_WR when the read data returns.
- COPY_WR goes back to COPY_RD after each write. When the length is used up it goes to NEXT, and on a pending stop it goes to IDLE.
- NEXT goes to FETCH for a non-zero next pointer, to DONE for a null pointer, and to IDLE on a pending stop.
- DONE goes to IDLE.

Top module: `cbdma_channel`

## Requirements
- R1: After reset every register reads zero, and no read or write request is presented to memory.
- R2: Register 0x04 holds the block pointer. On start the channel reads the first seven words of the block at byte address pointer×32, at offsets 0, 4, … 24, in that order. The word order is: transfer info, source low, source high, destination low, destination high, length in bytes, next pointer.
- R3: A block of length L copies L/4 words. The source address is {source-high[7:0], source-low}, and the destination address is built the same way. Each address steps by 4 after every word when bit 12 of its high word is set, and stays fixed otherwise.
- R4: A non-zero next pointer (same ×32 encoding) starts the next block with no software action. A null next pointer ends the chain and sets the end flag, status bit 1.
- R5: Writing 1 to status bit 1 clears the end flag. Writing 0 there leaves it unchanged.
- R6: When bit 0 of a block's transfer info is set, completing that block sets the interrupt flag (status bit 2) and drives `irq` high. Writing 1 to status bit 2 clears both.
- R7: A start while the block pointer is zero is ignored. The channel stays idle and issues no reads.
- R8: Writing the status register with bit 0 clear while the channel is active stops it. The channel finishes the word in flight, goes idle, and does not set the end flag. Status bit 7 reads 1 while a write request waits for acceptance.
- R9: A block whose length exceeds 0x4000_0000 bytes sets the error flag (status bit 10) and returns the channel to idle with no data moved. A length of exactly 0x4000_0000 is accepted. Writing 1 to bit 10 clears the error flag.
- R10: Registers 0x14/0x18 (source), 0x1C/0x20 (destination) and 0x24 (remaining length) show live progress. After a block they read the advanced addresses and a length of zero.
- R11: Status bits 23:16 and 29:28 are stored on every status write and read back. Register 0x0C stores and returns a full word. Writes to the block-field registers 0x10 to 0x28 are ignored.
- R12: A block of length zero makes no memory data access, and the chain moves on to its next block.
- R13: Writes to register 0x04 are ignored while the channel is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Interrupt, follows the interrupt flag |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 40 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_ready | input | 1 | Write request accepted |
| mem_wr_addr | output | 40 | Write byte address |
| mem_wr_data | output | 32 | Write data |

## Verification
The hardest case to reach from the ports is a stop that arrives while a write is pending, and seeing bit 7 set at that moment. The bench gets there by holding the write ready low from its memory model. It waits for the write request to appear, writes the block pointer and then a stop while the request stalls, and only then releases the ready. Exactly one word must land. Random ready stalls are also run under multi-block chains that include a zero-length block and random increment bits, and the results are compared with a shadow copy computed in the bench.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_COPY_RD, S_COPY_WR, S_NEXT, S_DONE
    } cb_state_t;

    localparam logic [7:0] OFF_CS   = 8'h00;
    localparam logic [7:0] OFF_CB   = 8'h04;
    localparam logic [7:0] OFF_DBG  = 8'h0C;
    localparam logic [7:0] OFF_TI   = 8'h10;
    localparam logic [7:0] OFF_SRC  = 8'h14;
    localparam logic [7:0] OFF_SRCH = 8'h18;
    localparam logic [7:0] OFF_DST  = 8'h1C;
    localparam logic [7:0] OFF_DSTH = 8'h20;
    localparam logic [7:0] OFF_LEN  = 8'h24;
    localparam logic [7:0] OFF_NXT  = 8'h28;

    localparam int CS_RUN   = 0;
    localparam int CS_END   = 1;
    localparam int CS_INT   = 2;
    localparam int CS_WWAIT = 7;
    localparam int CS_ERR   = 10;
    localparam int HI_INC   = 12;
    localparam int TI_INTEN = 0;

    localparam int CB_WORDS = 7;
endpackage

// File: rtl/cbdma_engine.sv
module cbdma_engine
    import cbdma_pkg::*;
#(
    parameter int          ADDR_W   = 40,
    parameter int          WORD_W   = 32,
    parameter int          CB_SHIFT = 5,
    parameter logic [31:0] MAX_LEN  = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cb_we,
    input  logic [WORD_W-1:0] cb_wdata,
    input  logic              start,
    input  logic              stop,
    output logic              busy,
    output logic              blk_int,
    output logic              chain_end,
    output logic              len_err,
    output logic [WORD_W-1:0] cb_ptr,
    output logic [WORD_W-1:0] ti_q,
    output logic [WORD_W-1:0] src_lo,
    output logic [WORD_W-1:0] src_hi,
    output logic [WORD_W-1:0] dst_lo,
    output logic [WORD_W-1:0] dst_hi,
    output logic [WORD_W-1:0] len_q,
    output logic [WORD_W-1:0] nxt_q,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data
);
    localparam int HI_W    = ADDR_W - WORD_W;
    localparam int STEP    = WORD_W / 8;
    localparam int STEP_SH = $clog2(STEP);
    localparam int IDX_W   = $clog2(CB_WORDS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CB_WORDS - 1);

    cb_state_t         state, state_nx;
    logic [IDX_W-1:0]  widx;
    logic              rd_pend, stop_q, rsp_take, len_bad;
    logic [WORD_W-1:0] data_q;
    logic [ADDR_W-1:0] src_addr, dst_addr, src_step, dst_step, cb_base;

    assign src_addr = {src_hi[HI_W-1:0], src_lo};
    assign dst_addr = {dst_hi[HI_W-1:0], dst_lo};
    assign src_step = src_hi[HI_INC] ? src_addr + ADDR_W'(STEP) : src_addr;
    assign dst_step = dst_hi[HI_INC] ? dst_addr + ADDR_W'(STEP) : dst_addr;
    assign cb_base  = ADDR_W'({cb_ptr, {CB_SHIFT{1'b0}}});
    assign rsp_take = rd_pend && mem_rsp_valid;
    assign len_bad  = len_q > MAX_LEN;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start && cb_ptr != '0) state_nx = S_FETCH;
            S_FETCH:   if (rsp_take && widx == LAST_IDX)
                           state_nx = len_bad ? S_IDLE :
                                      (len_q == '0) ? S_NEXT : S_COPY_RD;
            S_COPY_RD: if (rsp_take) state_nx = S_COPY_WR;
            S_COPY_WR: if (mem_wr_ready)
                           state_nx = (len_q <= WORD_W'(STEP)) ? S_NEXT :
                                      stop_q ? S_IDLE : S_COPY_RD;
            S_NEXT:    state_nx = stop_q ? S_IDLE :
                                  (nxt_q == '0) ? S_DONE : S_FETCH;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy         = state != S_IDLE;
        mem_rd_valid = !rd_pend && (state == S_FETCH || state == S_COPY_RD);
        mem_rd_addr  = (state == S_FETCH) ?
                       cb_base + (ADDR_W'(widx) << STEP_SH) : src_addr;
        mem_wr_valid = state == S_COPY_WR;
        mem_wr_addr  = dst_addr;
        mem_wr_data  = data_q;
        blk_int      = state == S_NEXT && ti_q[TI_INTEN];
        chain_end    = state == S_DONE;
        len_err      = state == S_FETCH && rsp_take && widx == LAST_IDX && len_bad;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx <= '0; rd_pend <= 1'b0; stop_q <= 1'b0; data_q <= '0;
            cb_ptr <= '0; ti_q <= '0; src_lo <= '0; src_hi <= '0;
            dst_lo <= '0; dst_hi <= '0; len_q <= '0; nxt_q <= '0;
        end else begin
            if (mem_rd_valid && mem_rd_ready) rd_pend <= 1'b1;
            else if (rsp_take)                rd_pend <= 1'b0;

            if (state == S_IDLE) stop_q <= 1'b0;
            else if (stop)       stop_q <= 1'b1;

            unique case (state)
                S_IDLE: begin
                    widx <= '0;
                    if (cb_we) cb_ptr <= cb_wdata;
                end
                S_FETCH: if (rsp_take) begin
                    widx <= widx + 1'b1;
                    unique case (widx)
                        IDX_W'(0): ti_q   <= mem_rsp_data;
                        IDX_W'(1): src_lo <= mem_rsp_data;
                        IDX_W'(2): src_hi <= mem_rsp_data;
                        IDX_W'(3): dst_lo <= mem_rsp_data;
                        IDX_W'(4): dst_hi <= mem_rsp_data;
                        IDX_W'(5): len_q  <= mem_rsp_data;
                        default:   nxt_q  <= mem_rsp_data;
                    endcase
                end
                S_COPY_RD: if (rsp_take) data_q <= mem_rsp_data;
                S_COPY_WR: if (mem_wr_ready) begin
                    src_lo <= src_step[WORD_W-1:0];
                    src_hi[HI_W-1:0] <= src_step[ADDR_W-1:WORD_W];
                    dst_lo <= dst_step[WORD_W-1:0];
                    dst_hi[HI_W-1:0] <= dst_step[ADDR_W-1:WORD_W];
                    len_q  <= (len_q <= WORD_W'(STEP)) ? '0 : len_q - WORD_W'(STEP);
                end
                S_NEXT: begin
                    widx <= '0;
                    if (!stop_q && nxt_q != '0) cb_ptr <= nxt_q;
                end
                default: ;
            endcase
        end
    end

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));
    p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_data)
                                          && $stable(mem_wr_addr));
    p_one_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_valid && mem_wr_valid));
    p_len_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid && mem_wr_ready && len_q > WORD_W'(STEP)
        |=> len_q == $past(len_q) - WORD_W'(STEP));
    p_start_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cb_ptr) != '0);
endmodule

// File: rtl/cbdma_regs.sv
module cbdma_regs
    import cbdma_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              start,
    output logic              stop,
    output logic              cb_we,
    input  logic              busy,
    input  logic              wr_waiting,
    input  logic              blk_int,
    input  logic              chain_end,
    input  logic              len_err,
    input  logic [WORD_W-1:0] cb_ptr,
    input  logic [WORD_W-1:0] ti_q,
    input  logic [WORD_W-1:0] src_lo,
    input  logic [WORD_W-1:0] src_hi,
    input  logic [WORD_W-1:0] dst_lo,
    input  logic [WORD_W-1:0] dst_hi,
    input  logic [WORD_W-1:0] len_q,
    input  logic [WORD_W-1:0] nxt_q
);
    logic              end_f, int_f, err_f, cs_we;
    logic [7:0]        prio_q;
    logic [1:0]        flag_q;
    logic [WORD_W-1:0] dbg_q, cs_word;

    assign cs_we = reg_we && reg_addr == OFF_CS;
    assign start = cs_we && reg_wdata[CS_RUN] && !busy;
    assign stop  = cs_we && !reg_wdata[CS_RUN] && busy;
    assign cb_we = reg_we && reg_addr == OFF_CB && !busy;
    assign irq   = int_f;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_f <= 1'b0; int_f <= 1'b0; err_f <= 1'b0;
            prio_q <= '0; flag_q <= '0; dbg_q <= '0;
        end else begin
            if (chain_end)                    end_f <= 1'b1;
            else if (cs_we && reg_wdata[CS_END]) end_f <= 1'b0;
            if (blk_int)                      int_f <= 1'b1;
            else if (cs_we && reg_wdata[CS_INT]) int_f <= 1'b0;
            if (len_err)                      err_f <= 1'b1;
            else if (cs_we && reg_wdata[CS_ERR]) err_f <= 1'b0;
            if (cs_we) begin
                prio_q <= reg_wdata[23:16];
                flag_q <= reg_wdata[29:28];
            end
            if (reg_we && reg_addr == OFF_DBG) dbg_q <= reg_wdata;
        end
    end

    always_comb begin
        cs_word           = '0;
        cs_word[CS_RUN]   = busy;
        cs_word[CS_END]   = end_f;
        cs_word[CS_INT]   = int_f;
        cs_word[CS_WWAIT] = wr_waiting;
        cs_word[CS_ERR]   = err_f;
        cs_word[23:16]    = prio_q;
        cs_word[29:28]    = flag_q;
        unique case (reg_addr)
            OFF_CS:   reg_rdata = cs_word;
            OFF_CB:   reg_rdata = cb_ptr;
            OFF_DBG:  reg_rdata = dbg_q;
            OFF_TI:   reg_rdata = ti_q;
            OFF_SRC:  reg_rdata = src_lo;
            OFF_SRCH: reg_rdata = src_hi;
            OFF_DST:  reg_rdata = dst_lo;
            OFF_DSTH: reg_rdata = dst_hi;
            OFF_LEN:  reg_rdata = len_q;
            OFF_NXT:  reg_rdata = nxt_q;
            default:  reg_rdata = '0;
        endcase
    end

    p_end_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_we && reg_wdata[CS_END] && !chain_end |=> !end_f);
    p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_f) |-> !busy);
    p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        blk_int |=> irq);
endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
    import cbdma_pkg::*;
#(
    parameter int          ADDR_W   = 40,
    parameter int          WORD_W   = 32,
    parameter int          CB_SHIFT = 5,
    parameter logic [31:0] MAX_LEN  = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [WORD_W-1:0] mem_wr_data
);
    logic start, stop, cb_we, busy, blk_int, chain_end, len_err;
    logic [WORD_W-1:0] cb_ptr, ti_q, src_lo, src_hi, dst_lo, dst_hi, len_q, nxt_q;

    cbdma_regs #(.WORD_W(WORD_W)) u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq,
        .start, .stop, .cb_we, .busy, .wr_waiting(mem_wr_valid),
        .blk_int, .chain_end, .len_err,
        .cb_ptr, .ti_q, .src_lo, .src_hi, .dst_lo, .dst_hi, .len_q, .nxt_q
    );

    cbdma_engine #(
        .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CB_SHIFT(CB_SHIFT), .MAX_LEN(MAX_LEN)
    ) u_engine (
        .clk, .rst_n, .cb_we, .cb_wdata(reg_wdata), .start, .stop,
        .busy, .blk_int, .chain_end, .len_err,
        .cb_ptr, .ti_q, .src_lo, .src_hi, .dst_lo, .dst_hi, .len_q, .nxt_q,
        .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
        .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data
    );
endmodule

// File: tb/tb_cbdma_channel.sv
module tb_cbdma_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        mem_rd_valid, mem_wr_valid;
    logic        mem_rd_ready = 1'b0, mem_wr_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = 32'h0;
    logic [39:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_wr_data;

    always #2.5 clk = ~clk;

    cbdma_channel dut (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq,
        .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
        .mem_wr_valid, .mem_wr_ready, .mem_wr_addr, .mem_wr_data
    );

    int checks = 0, fails = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] exp_mem [0:1023];
    logic [39:0] rd_log [0:511];
    int rd_n = 0, wr_n = 0, wr_hi_bad = 0;
    bit rnd_on = 0, wr_hold = 0;
    int unsigned nw [0:2];
    bit sinc [0:2];
    bit dinc [0:2];

    // memory model
    initial begin
        forever begin
            @(posedge clk);
            if (mem_rd_valid && mem_rd_ready) begin
                mem_rsp_data  <= mem[mem_rd_addr[11:2]];
                mem_rsp_valid <= 1'b1;
                rd_log[rd_n % 512] = mem_rd_addr;
                rd_n = rd_n + 1;
            end else mem_rsp_valid <= 1'b0;
            if (mem_wr_valid && mem_wr_ready) begin
                mem[mem_wr_addr[11:2]] = mem_wr_data;
                wr_n = wr_n + 1;
                if (mem_wr_addr[39:32] != 8'h0A) wr_hi_bad = wr_hi_bad + 1;
            end
            mem_rd_ready <= rnd_on ? ($urandom % 3 != 0) : 1'b1;
            mem_wr_ready <= wr_hold ? 1'b0 : rnd_on ? ($urandom % 3 != 0) : 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            reg_read(8'h00, s);
            if (!s[0]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic put_cb(input int ba, input logic [31:0] ti, sl, sh, dl, dh,
                          len, nx);
        mem[ba/4+0] = ti; mem[ba/4+1] = sl; mem[ba/4+2] = sh; mem[ba/4+3] = dl;
        mem[ba/4+4] = dh; mem[ba/4+5] = len; mem[ba/4+6] = nx; mem[ba/4+7] = 0;
    endtask

    task automatic model_block(input int sb, input bit si, input int db,
                               input bit di, input int n);
        for (int k = 0; k < n; k++)
            exp_mem[(db + (di ? 4*k : 0))/4] = exp_mem[(sb + (si ? 4*k : 0))/4];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %h expected %h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base, rbase;
        bit ok;
        void'($urandom(32'd4242));
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(8'h00, v); check(v == 0, "R1", "status", v, 0);
        reg_read(8'h04, v); check(v == 0, "R1", "pointer", v, 0);
        reg_read(8'h24, v); check(v == 0, "R1", "length", v, 0);
        reg_read(8'h14, v); check(v == 0, "R1", "source", v, 0);
        check(!mem_rd_valid && !mem_wr_valid && !irq, "R1", "requests",
              {mem_rd_valid, mem_wr_valid, irq}, 0);

        // single block, 4 words
        for (int k = 0; k < 4; k++) mem[(12'h800/4)+k] = $urandom;
        put_cb(12'h200, 32'h1, 32'h800, 32'h5F0A | (1 << 12), 32'hC00,
               32'h000A | (1 << 12), 16, 0);
        rbase = rd_n; base = wr_n;
        reg_write(8'h04, 32'h10);
        reg_write(8'h00, 32'h1);
        wait_idle();
        ok = 1;
        for (int k = 0; k < 7; k++)
            if (rd_log[(rbase + k) % 512] != 40'(12'h200 + 4*k)) ok = 0;
        check(ok, "R2", "fetch order", rd_log[rbase % 512], 40'h200);
        ok = 1;
        for (int k = 0; k < 4; k++) if (mem[(12'hC00/4)+k] != mem[(12'h800/4)+k]) ok = 0;
        check(ok, "R3", "copied data", mem[12'hC00/4], mem[12'h800/4]);
        check(wr_n - base == 4, "R3", "word count", wr_n - base, 4);
        check(wr_hi_bad == 0, "R3", "addr bits 39:32", wr_hi_bad, 0);
        reg_read(8'h00, v);
        check(v[1], "R4", "end flag", v, 32'h2);
        check(v[2] && irq, "R6", "interrupt", {v[2], irq}, 2'b11);
        reg_read(8'h14, v); check(v == 32'h810, "R10", "source low", v, 32'h810);
        reg_read(8'h20, v); check(v == 32'h100A, "R10", "dest high", v, 32'h100A);
        reg_read(8'h1C, v); check(v == 32'hC10, "R10", "dest low", v, 32'hC10);
        reg_read(8'h24, v); check(v == 0, "R10", "length left", v, 0);

        // R5 / R6 clear rules
        reg_write(8'h00, 32'h0);
        reg_read(8'h00, v); check(v[1] && v[2], "R5", "write 0 keeps flags", v, 32'h6);
        reg_write(8'h00, 32'h2);
        reg_read(8'h00, v); check(!v[1] && v[2], "R5", "end cleared", v, 32'h4);
        reg_write(8'h00, 32'h4);
        reg_read(8'h00, v); check(!v[2] && !irq, "R6", "int cleared", {v[2], irq}, 0);

        // random chains with stalls, middle block empty
        rnd_on = 1;
        for (int it = 0; it < 4; it++) begin
            for (int b = 0; b < 3; b++) begin
                nw[b] = (b == 1) ? 0 : 1 + $urandom % 6;
                sinc[b] = 1'($urandom % 2); dinc[b] = 1'($urandom % 2);
                for (int k = 0; k < 8; k++) begin
                    mem[(12'h800 + 256*b)/4 + k] = $urandom;
                    mem[(12'hC00 + 256*b)/4 + k] = 0;
                end
                put_cb(64*(b+1), (b == 2) ? 32'h1 : 32'h0, 32'h800 + 256*b,
                       32'h0A | (32'(sinc[b]) << 12) | (2 << 13) | (15 << 8),
                       32'hC00 + 256*b, 32'h0A | (32'(dinc[b]) << 12),
                       nw[b]*4, (b < 2) ? 2*(b+2) : 0);
            end
            for (int i = 0; i < 1024; i++) exp_mem[i] = mem[i];
            for (int b = 0; b < 3; b++)
                model_block(12'h800 + 256*b, sinc[b], 12'hC00 + 256*b, dinc[b], nw[b]);
            base = wr_n;
            reg_write(8'h04, 32'h2);
            reg_write(8'h00, 32'h1);
            wait_idle();
            ok = 1;
            for (int i = 12'hC00/4; i < 12'hF00/4; i++) if (mem[i] != exp_mem[i]) ok = 0;
            check(ok, "R3", "chain data", it, it);
            check(wr_n - base == nw[0] + nw[2], "R12", "writes in chain",
                  wr_n - base, nw[0] + nw[2]);
            reg_read(8'h00, v);
            check(v[1] && v[2], "R4", "chain end and int", v, 32'h6);
            reg_read(8'h04, v); check(v == 6, "R4", "last pointer", v, 6);
            reg_write(8'h00, 32'h6);
        end
        check(wr_hi_bad == 0, "R3", "addr bits 39:32 chain", wr_hi_bad, 0);
        rnd_on = 0;

        // R7: null pointer start
        reg_write(8'h04, 32'h0);
        rbase = rd_n;
        reg_write(8'h00, 32'h1);
        repeat (5) @(negedge clk);
        reg_read(8'h00, v); check(!v[0], "R7", "stays idle", v, 0);
        check(rd_n == rbase, "R7", "no reads", rd_n - rbase, 0);

        // R11: stored fields
        reg_write(8'h00, 32'h30A5_0000);
        reg_read(8'h00, v);
        check(v == 32'h30A5_0000, "R11", "status fields", v, 32'h30A5_0000);
        reg_write(8'h0C, 32'h1234_5678);
        reg_read(8'h0C, v); check(v == 32'h1234_5678, "R11", "debug", v, 32'h1234_5678);
        reg_write(8'h24, 32'hDEAD);
        reg_read(8'h24, v); check(v == 0, "R11", "length ignores write", v, 0);
        reg_write(8'h00, 32'h0);

        // R8 / R13: stop during a held write
        put_cb(12'h100, 32'h0, 32'h800, 32'h100A, 32'hC00, 32'h100A, 256, 32'h10);
        wr_hold = 1; base = wr_n;
        reg_write(8'h04, 32'h8);
        reg_write(8'h00, 32'h1);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (mem_wr_valid) break;
        end
        reg_read(8'h00, v);
        check(v[0] && v[7], "R8", "write waiting bit", v, 32'h81);
        reg_write(8'h04, 32'h20);
        reg_read(8'h04, v); check(v == 32'h8, "R13", "pointer locked", v, 32'h8);
        reg_write(8'h00, 32'h0);
        wr_hold = 0;
        wait_idle();
        check(wr_n - base == 1, "R8", "one word after stop", wr_n - base, 1);
        reg_read(8'h00, v); check(!v[1] && !v[7], "R8", "no end after stop", v, 0);
        reg_read(8'h24, v); check(v == 252, "R8", "length left", v, 252);

        // R9: length limit
        put_cb(12'h140, 32'h0, 32'h800, 32'h100A, 32'hC00, 32'h100A,
               32'h4000_0004, 0);
        base = wr_n;
        reg_write(8'h04, 32'hA);
        reg_write(8'h00, 32'h1);
        wait_idle();
        reg_read(8'h00, v);
        check(v[10] && !v[1], "R9", "error flag", v, 32'h400);
        check(wr_n == base, "R9", "no data moved", wr_n - base, 0);
        reg_write(8'h00, 32'h400);
        reg_read(8'h00, v); check(!v[10], "R9", "error cleared", v, 0);
        mem[12'h140/4 + 5] = 32'h4000_0000;
        base = wr_n;
        reg_write(8'h00, 32'h1);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (wr_n - base >= 2) break;
        end
        reg_write(8'h00, 32'h0);
        wait_idle();
        reg_read(8'h00, v); check(!v[10], "R9", "limit accepted", v, 0);
        reg_read(8'h24, v);
        check(v == 32'h4000_0000 - 4*(wr_n - base), "R9", "limit length",
              v, 32'h4000_0000 - 4*(wr_n - base));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule